// File: doc/BRIEF.md
# Eight-Pin Mode-Configurable GPIO Port

This block is one general-purpose I/O port with eight pins. Software sets each pin through a 2-bit mode field in a 16-bit control word. A field can hand the pin to a peripheral, make it a driven output, or make it an input with or without a pull-up. An 8-bit data word holds the value that output pins drive. When it is read, it returns either that stored value or the synchronized pad level, depending on each pin's mode.

Two elaboration parameters limit individual pins. An input-forbidden mask keeps a pin to the peripheral and output modes. A locked mask marks fields that have no physical pin behind them. Such fields ignore writes and stay quiet. The block sits between a simple synchronous register bus and the pad ring. Peripheral out and output-enable signals arrive per pin and are passed to the pad when the pin is in peripheral mode.

Top module: `pinmode_port`

## Requirements
- R1: Pin i owns control bits [2i+1:2i], so pin 7 is bits 15:14 and pin 0 is bits 1:0. A control write followed by a control read returns each configurable field as written.
- R2: In mode 00 (peripheral), pad_out[i] and pad_oe[i] equal alt_out[i] and alt_oe[i] in the same cycle, and pad_pu[i] is 0.
- R3: In mode 01 (output), pad_oe[i] is 1, pad_out[i] is the stored data bit i, and pad_pu[i] is 0.
- R4: In mode 10, pad_oe[i] is 0 and pad_pu[i] is 1. In mode 11, both are 0.
- R5: A data read returns the stored bit for mode-01 pins. For modes 00, 10 and 11 it returns pad_in through a two-flop synchronizer: a pad change applied before clock edge k is still hidden after edge k and is visible after edge k+1.
- R6: A data write updates the stored bit of every unlocked pin, whatever its mode. A pin in mode 00 keeps driving from alt_out. After the pin is switched to mode 01, the stored bit appears on pad_out.
- R7: On a pin in NO_INPUT_MASK, a control write carrying mode 10 or 11 leaves that field unchanged. Other fields in the same write still update.
- R8: On a pin in LOCKED_MASK, the control field reads 00, writes to it are ignored, its data bit reads 0, and pad_out, pad_oe and pad_pu are 0.
- R9: After reset, unlocked pins outside NO_INPUT_MASK are in mode 11, pins in NO_INPUT_MASK are in mode 00, and every stored data bit is 0.
- R10: bus_sel 0 addresses the 16-bit control word and bus_sel 1 the data word. Data writes use bus_wdata[7:0]. Data reads return zeros in bus_rdata[15:8]. bus_rdata is combinational on bus_sel in the same cycle. A write takes effect at the next rising clock edge.
- R11: The control word changes only on a control write (bus_we 1 with bus_sel 0). A data write leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register select: 0 control, 1 data |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the selected register |
| pad_in | input | 8 | Pad input levels (asynchronous) |
| pad_out | output | 8 | Pad output values |
| pad_oe | output | 8 | Pad output enables |
| pad_pu | output | 8 | Pad pull-up enables |
| alt_out | input | 8 | Peripheral output values per pin |
| alt_oe | input | 8 | Peripheral output enables per pin |

## Verification
The bench targets several ways the block could go wrong, and each shows up as a specific symptom:
- **Synchronizer depth.** The bench reads data one edge after a pad change and again one edge later. A synchronizer one stage short would show the new level too early. One stage too long would still show the old level.
- **Forbidden input modes.** All-ones and mixed control words go to the input-forbidden pins. A design that clamps the value instead of keeping the old field would read back a changed field. A design that drops the whole write would leave the neighbouring fields stale.
- **Locked field.** The bench writes all ones to the locked field and drives all-ones peripheral inputs. A leaky lock would read back nonzero or drive the pad.
- **Peripheral-mode writes.** The bench writes data to a pin in peripheral mode. A design that let the latch leak into peripheral mode would change pad_out at once. A design that ignored the write would show the wrong bit once the pin becomes an output.

// File: rtl/pinmode_pkg.sv
package pinmode_pkg;

   typedef enum logic [1:0] {
      MODE_ALT    = 2'b00,
      MODE_OUT    = 2'b01,
      MODE_IN_PU  = 2'b10,
      MODE_IN_NPU = 2'b11
   } pin_mode_t;

   localparam int unsigned MODE_W = 2;

endpackage

// File: rtl/pinmode_sync.sv
module pinmode_sync #(
   parameter int unsigned WIDTH  = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("pinmode_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0][WIDTH-1:0] chain;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         chain <= '0;
      end else begin
         chain[0] <= d;
         for (int s = 1; s < STAGES; s++) begin
            chain[s] <= chain[s-1];
         end
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/pinmode_cell.sv
module pinmode_cell
   import pinmode_pkg::*;
#(
   parameter bit NO_INPUT = 1'b0,
   parameter bit LOCKED   = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ctrl_we,
   input  logic [MODE_W-1:0] mode_wr,
   input  logic              data_we,
   input  logic              data_wr,
   input  logic              pad_sync,
   input  logic              alt_out,
   input  logic              alt_oe,
   output logic [MODE_W-1:0] mode_q,
   output logic              rd_bit,
   output logic              pad_out,
   output logic              pad_oe,
   output logic              pad_pu
);

   if (LOCKED) begin : g_locked
      logic unused_in;
      assign unused_in = ^{clk, rst_n, ctrl_we, mode_wr, data_we, data_wr,
                           pad_sync, alt_out, alt_oe};
      assign mode_q  = MODE_ALT;
      assign rd_bit  = 1'b0;
      assign pad_out = 1'b0;
      assign pad_oe  = 1'b0;
      assign pad_pu  = 1'b0;
   end else begin : g_live
      localparam pin_mode_t RST_MODE = NO_INPUT ? MODE_ALT : MODE_IN_NPU;

      pin_mode_t mode_r;
      logic      latch_r;
      logic      accept;

      // an input-forbidden pin drops any write whose upper mode bit is set
      assign accept = ctrl_we && !(NO_INPUT && mode_wr[1]);

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            mode_r  <= RST_MODE;
            latch_r <= 1'b0;
         end else begin
            if (accept)  mode_r  <= pin_mode_t'(mode_wr);
            if (data_we) latch_r <= data_wr;
         end
      end

      always_comb begin
         pad_out = latch_r;
         pad_oe  = 1'b0;
         pad_pu  = 1'b0;
         rd_bit  = pad_sync;
         unique case (mode_r)
            MODE_ALT: begin
               pad_out = alt_out;
               pad_oe  = alt_oe;
            end
            MODE_OUT: begin
               pad_oe = 1'b1;
               rd_bit = latch_r;
            end
            MODE_IN_PU:  pad_pu = 1'b1;
            MODE_IN_NPU: pad_pu = 1'b0;
            default: ;
         endcase
      end

      assign mode_q = mode_r;
   end

endmodule

// File: rtl/pinmode_port.sv
module pinmode_port
   import pinmode_pkg::*;
#(
   parameter int unsigned   NUM_PINS      = 8,
   parameter int unsigned   SYNC_STAGES   = 2,
   parameter logic [7:0]    NO_INPUT_MASK = 8'h00,
   parameter logic [7:0]    LOCKED_MASK   = 8'h00
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bus_sel,
   input  logic                 bus_we,
   input  logic [15:0]          bus_wdata,
   output logic [15:0]          bus_rdata,
   input  logic [NUM_PINS-1:0]  pad_in,
   output logic [NUM_PINS-1:0]  pad_out,
   output logic [NUM_PINS-1:0]  pad_oe,
   output logic [NUM_PINS-1:0]  pad_pu,
   input  logic [NUM_PINS-1:0]  alt_out,
   input  logic [NUM_PINS-1:0]  alt_oe
);

   localparam int unsigned CTRL_W = NUM_PINS * MODE_W;
   localparam int unsigned PAD_W  = CTRL_W - NUM_PINS;

   if (NUM_PINS != 8) begin : g_bad_pins
      $error("pinmode_port: NUM_PINS must be 8 to fit the 16-bit bus");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("pinmode_port: SYNC_STAGES must be at least 2");
   end

   logic [NUM_PINS-1:0] pad_sync;
   logic [NUM_PINS-1:0] data_view;
   logic [CTRL_W-1:0]   ctrl_view;
   logic                ctrl_we;
   logic                data_we;

   assign ctrl_we = bus_we && !bus_sel;
   assign data_we = bus_we &&  bus_sel;

   pinmode_sync #(
      .WIDTH  (NUM_PINS),
      .STAGES (SYNC_STAGES)
   ) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (pad_in),
      .q     (pad_sync)
   );

   for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
      pinmode_cell #(
         .NO_INPUT (NO_INPUT_MASK[i]),
         .LOCKED   (LOCKED_MASK[i])
      ) i_cell (
         .clk      (clk),
         .rst_n    (rst_n),
         .ctrl_we  (ctrl_we),
         .mode_wr  (bus_wdata[MODE_W*i +: MODE_W]),
         .data_we  (data_we),
         .data_wr  (bus_wdata[i]),
         .pad_sync (pad_sync[i]),
         .alt_out  (alt_out[i]),
         .alt_oe   (alt_oe[i]),
         .mode_q   (ctrl_view[MODE_W*i +: MODE_W]),
         .rd_bit   (data_view[i]),
         .pad_out  (pad_out[i]),
         .pad_oe   (pad_oe[i]),
         .pad_pu   (pad_pu[i])
      );
   end

   assign bus_rdata = bus_sel ? {{PAD_W{1'b0}}, data_view} : ctrl_view;

endmodule

// File: rtl/pinmode_port_chk.sv
module pinmode_port_chk #(
   parameter int unsigned NUM_PINS      = 8,
   parameter logic [7:0]  NO_INPUT_MASK = 8'h00,
   parameter logic [7:0]  LOCKED_MASK   = 8'h00
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  bus_sel,
   input logic                  bus_we,
   input logic [15:0]           bus_rdata,
   input logic [2*NUM_PINS-1:0] ctrl_view,
   input logic [NUM_PINS-1:0]   pad_out,
   input logic [NUM_PINS-1:0]   pad_oe,
   input logic [NUM_PINS-1:0]   pad_pu,
   input logic [NUM_PINS-1:0]   alt_out,
   input logic [NUM_PINS-1:0]   alt_oe
);

   AST_CTRL_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_we && !bus_sel) |=> $stable(ctrl_view)); // R11

   AST_DATA_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      bus_sel |-> (bus_rdata[15:8] == 8'h00)); // R10

   for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
      AST_OUT_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
         (ctrl_view[2*i +: 2] == 2'b01) |-> (pad_oe[i] && !pad_pu[i])); // R3

      AST_INPUT_FLOATS: assert property (@(posedge clk) disable iff (!rst_n)
         ctrl_view[2*i+1] |-> !pad_oe[i]); // R4

      AST_PULLUP_ONLY_MODE10: assert property (@(posedge clk) disable iff (!rst_n)
         pad_pu[i] |-> (ctrl_view[2*i +: 2] == 2'b10)); // R4

      AST_ALT_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
         (!LOCKED_MASK[i] && ctrl_view[2*i +: 2] == 2'b00)
         |-> (pad_oe[i] == alt_oe[i] && pad_out[i] == alt_out[i] && !pad_pu[i])); // R2

      AST_NO_INPUT_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
         NO_INPUT_MASK[i] |-> !ctrl_view[2*i+1]); // R7

      AST_LOCKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
         LOCKED_MASK[i] |-> (ctrl_view[2*i +: 2] == 2'b00 && !pad_oe[i]
                             && !pad_pu[i] && !pad_out[i])); // R8
   end

endmodule

bind pinmode_port pinmode_port_chk #(
   .NUM_PINS      (NUM_PINS),
   .NO_INPUT_MASK (NO_INPUT_MASK),
   .LOCKED_MASK   (LOCKED_MASK)
) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_sel   (bus_sel),
   .bus_we    (bus_we),
   .bus_rdata (bus_rdata),
   .ctrl_view (ctrl_view),
   .pad_out   (pad_out),
   .pad_oe    (pad_oe),
   .pad_pu    (pad_pu),
   .alt_out   (alt_out),
   .alt_oe    (alt_oe)
);

// File: tb/test_pinmode_port.sv
module test_pinmode_port;

   // pins 5 and 6 refuse input modes, pin 7 is locked
   localparam logic [7:0] NOIN = 8'b0110_0000;
   localparam logic [7:0] LOCK = 8'b1000_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_we = 1'b0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic [7:0]  pad_in = '0;
   logic [7:0]  pad_out, pad_oe, pad_pu;
   logic [7:0]  alt_out = '0;
   logic [7:0]  alt_oe = '0;

   int n_checks = 0;
   int n_fail = 0;

   always #4 clk = ~clk; // 125 MHz

   pinmode_port #(
      .NO_INPUT_MASK (NOIN),
      .LOCKED_MASK   (LOCK)
   ) i_pinmode_port (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_sel   (bus_sel),
      .bus_we    (bus_we),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .pad_in    (pad_in),
      .pad_out   (pad_out),
      .pad_oe    (pad_oe),
      .pad_pu    (pad_pu),
      .alt_out   (alt_out),
      .alt_oe    (alt_oe)
   );

   task automatic check(string req, string what, logic [15:0] act, logic [15:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // called at a falling edge; the write lands on the next rising edge
   task automatic wr(logic sel, logic [15:0] val);
      @(negedge clk);
      bus_sel = sel; bus_wdata = val; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(logic sel, output logic [15:0] val);
      bus_sel = sel;
      #1;
      val = bus_rdata;
   endtask

   task automatic t_reset();
      logic [15:0] v;
      @(negedge clk);
      rd(1'b0, v); check("R9", "reset control", v, 16'h03FF);
      rd(1'b1, v); check("R9", "reset data", v, 16'h0000);
      check("R9", "reset pad_oe", {8'h00, pad_oe}, 16'h0000);
      check("R9", "reset pad_pu", {8'h00, pad_pu}, 16'h0000);
   endtask

   task automatic t_layout();
      logic [15:0] v;
      // pin7 01(locked) pin6 00 pin5 01 pin4 01 pin3 00 pin2 11 pin1 10 pin0 01
      wr(1'b0, 16'h4539);
      rd(1'b0, v); check("R1", "field readback", v, 16'h0539);
      check("R8", "locked field ignores write", v & 16'hC000, 16'h0000);
   endtask

   task automatic t_pads();
      wr(1'b1, 16'h003B);
      alt_out = 8'h00; alt_oe = 8'hFF;
      #1;
      check("R3", "pad_oe outputs+alt", {8'h00, pad_oe}, 16'h0079);
      check("R3", "pad_out latch", {8'h00, pad_out}, 16'h0033);
      check("R4", "pad_pu mode10 only", {8'h00, pad_pu}, 16'h0002);
      alt_out = 8'hFF; alt_oe = 8'h00;
      #1;
      check("R2", "pad_oe follows alt", {8'h00, pad_oe}, 16'h0031);
      check("R2", "pad_out follows alt", {8'h00, pad_out}, 16'h007B);
   endtask

   task automatic t_sync();
      logic [15:0] v;
      @(negedge clk);
      pad_in = 8'h55;
      @(negedge clk);
      rd(1'b1, v); check("R5", "one edge after pad change", v, 16'h0031);
      @(negedge clk);
      rd(1'b1, v); check("R5", "two edges after pad change", v, 16'h0075);
   endtask

   task automatic t_special_write();
      logic [15:0] v;
      alt_out = 8'h00; alt_oe = 8'h00;
      wr(1'b1, 16'h0008);
      #1;
      check("R6", "alt pin ignores latch", {8'h00, pad_out}, 16'h0000);
      check("R6", "pad_oe unchanged", {8'h00, pad_oe}, 16'h0031);
      wr(1'b0, 16'h0579);
      #1;
      check("R6", "latched bit drives once output", {8'h00, pad_out}, 16'h0008);
      check("R3", "pad_oe with pin3 output", {8'h00, pad_oe}, 16'h0039);
      rd(1'b1, v); check("R5", "mixed-mode read", v, 16'h004C);
   endtask

   task automatic t_forbidden();
      logic [15:0] v;
      wr(1'b0, 16'hFFFF);
      rd(1'b0, v); check("R7", "all-ones write", v, 16'h07FF);
      wr(1'b0, 16'h2000);
      rd(1'b0, v); check("R7", "pin6 mode10 rejected, others update", v, 16'h0000);
      wr(1'b0, 16'h1000);
      rd(1'b0, v); check("R7", "pin6 mode01 accepted", v, 16'h1000);
   endtask

   task automatic t_locked();
      logic [15:0] v;
      pad_in = 8'hFF; alt_out = 8'hFF; alt_oe = 8'hFF;
      wr(1'b1, 16'h00FF);
      repeat (3) @(negedge clk);
      rd(1'b1, v); check("R8", "locked data bit reads 0", v, 16'h007F);
      check("R8", "locked pad_oe", {8'h00, pad_oe}, 16'h007F);
      check("R8", "locked pad_out", {8'h00, pad_out}, 16'h007F);
      check("R8", "locked pad_pu", {8'h00, pad_pu}, 16'h0000);
   endtask

   task automatic t_bus();
      logic [15:0] v;
      wr(1'b1, 16'hAB00);
      rd(1'b0, v); check("R11", "data write keeps control", v, 16'h1000);
      rd(1'b1, v); check("R10", "data read low byte only", v, 16'h003F);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_layout();
      t_pads();
      t_sync();
      t_special_write();
      t_forbidden();
      t_locked();
      t_bus();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog all requirements: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule